// File: doc/BRIEF.md
# Word-Addressed Instruction Fetch Unit

This unit holds the program counter of a simple processor and produces, every cycle, the byte address sent to instruction memory, the instruction word that comes back, and the address of the next sequential instruction. Instructions are word aligned, so the low two bits of every fetch address are always zero. The unit stores only the word index, which is the upper 30 bits of the byte address. The zero bits are appended when the byte address is formed.

Each clock edge the word index moves forward by one. When the branch-taken input is high, the edge instead adds one plus the sign-extended 16-bit branch offset, counted in words. The instruction memory sits outside the unit and responds combinationally. The word it returns is passed straight through to the rest of the core in the same cycle. The surrounding control logic decides whether a branch is taken and supplies the offset.

Top module: `ifu_fetch_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets the word index to 0, so `imem_addr` reads 0x00000000 after that edge.
- R2: `imem_addr` equals the 30-bit word index followed by two zero bits. Bits [1:0] of `imem_addr` are always 0.
- R3: At an edge with `rst` and `br_taken` low, `imem_addr` grows by 4, so the word index grows by 1.
- R4: At an edge with `br_taken` high and `rst` low, the word index becomes old index + 1 + the sign-extended `br_imm`. The byte address therefore moves by 4 + 4*offset.
- R5: `br_imm` is a two's-complement word offset and bit 15 is its sign. For example, 16'hFFFE steps the index back by one word in total (+1 - 2).
- R6: Word-index arithmetic wraps modulo 2^30. Index 0x3FFFFFFF followed by a sequential edge gives index 0.
- R7: `pc_plus4` equals `imem_addr` + 4 modulo 2^32 in every cycle, including 0 at address 0xFFFFFFFC.
- R8: `instr` equals `imem_rdata` in the same cycle as the address that selected it.
- R9: Reset takes priority over a branch. `rst` and `br_taken` high at the same edge still give address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| br_taken | input | 1 | Use the branch target at the next edge |
| br_imm | input | 16 | Signed branch offset in words |
| imem_addr | output | 32 | Byte address to instruction memory |
| imem_rdata | input | 32 | Word returned by instruction memory |
| instr | output | 32 | Fetched instruction word |
| pc_plus4 | output | 32 | Address of the next sequential instruction |

## Verification
Two events can fall on the same edge: reset, and a taken branch with a nonzero offset. The bench raises `br_taken` with a large offset while `rst` is high. It then expects address 0 rather than the branch target. A second overlap occurs when a negative branch lands on the top word and the sequential step wraps it. At that point the bench expects the address to wrap to zero, and `pc_plus4` to wrap with it.

// File: rtl/ifu_pkg.sv
package ifu_pkg;
   localparam int unsigned IFU_ADDR_W  = 32;
   localparam int unsigned IFU_ALIGN_W = 2;
   localparam int unsigned IFU_IMM_W   = 16;

   typedef enum logic {
      NPC_SEQ    = 1'b0,
      NPC_BRANCH = 1'b1
   } npc_sel_e;
endpackage

// File: rtl/ifu_pc_reg.sv
module ifu_pc_reg #(
   parameter int unsigned WORD_W = 30
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [WORD_W-1:0] d_word,
   output logic [WORD_W-1:0] q_word
);
   if (WORD_W < 1) begin : g_bad_width
      $error("ifu_pc_reg: WORD_W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (rst) q_word <= '0;
      else     q_word <= d_word;
   end

   AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (q_word == '0)); // R1
endmodule

// File: rtl/ifu_next_pc.sv
module ifu_next_pc
   import ifu_pkg::*;
#(
   parameter int unsigned WORD_W = 30,
   parameter int unsigned IMM_W  = 16
) (
   input  logic              [WORD_W-1:0] cur_word,
   input  npc_sel_e                        sel,
   input  logic              [IMM_W-1:0]  imm,
   output logic              [WORD_W-1:0] inc_word,
   output logic              [WORD_W-1:0] nxt_word
);
   logic [WORD_W-1:0] imm_ext;

   if (IMM_W < 2) begin : g_bad_imm
      $error("ifu_next_pc: IMM_W must be at least 2");
   end

   if (IMM_W < WORD_W) begin : g_sext
      localparam int unsigned FILL_W = WORD_W - IMM_W;
      assign imm_ext = {{FILL_W{imm[IMM_W-1]}}, imm};
   end else begin : g_trunc
      assign imm_ext = imm[WORD_W-1:0];
   end

   always_comb begin
      inc_word = cur_word + WORD_W'(1);
      unique case (sel)
         NPC_BRANCH: nxt_word = inc_word + imm_ext;
         default:    nxt_word = inc_word;
      endcase
   end
endmodule

// File: rtl/ifu_addr_fmt.sv
module ifu_addr_fmt #(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned ALIGN_W = 2
) (
   input  logic [ADDR_W-ALIGN_W-1:0] cur_word,
   input  logic [ADDR_W-ALIGN_W-1:0] inc_word,
   output logic [ADDR_W-1:0]         cur_byte,
   output logic [ADDR_W-1:0]         inc_byte
);
   if (ALIGN_W >= ADDR_W) begin : g_bad_align
      $error("ifu_addr_fmt: ALIGN_W must be below ADDR_W");
   end

   if (ALIGN_W == 0) begin : g_byte
      assign cur_byte = cur_word;
      assign inc_byte = inc_word;
   end else begin : g_pad
      assign cur_byte = {cur_word, {ALIGN_W{1'b0}}};
      assign inc_byte = {inc_word, {ALIGN_W{1'b0}}};
   end
endmodule

// File: rtl/ifu_fetch_unit.sv
module ifu_fetch_unit
   import ifu_pkg::*;
#(
   parameter int unsigned ADDR_W  = IFU_ADDR_W,
   parameter int unsigned ALIGN_W = IFU_ALIGN_W,
   parameter int unsigned IMM_W   = IFU_IMM_W,
   parameter int unsigned INST_W  = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              br_taken,
   input  logic [IMM_W-1:0]  br_imm,
   output logic [ADDR_W-1:0] imem_addr,
   input  logic [INST_W-1:0] imem_rdata,
   output logic [INST_W-1:0] instr,
   output logic [ADDR_W-1:0] pc_plus4
);
   localparam int unsigned WORD_W = ADDR_W - ALIGN_W;
   localparam int unsigned STEP_B = 1 << ALIGN_W;

   if (ADDR_W < 8) begin : g_bad_addr
      $error("ifu_fetch_unit: ADDR_W too small");
   end

   logic [WORD_W-1:0] word_q;
   logic [WORD_W-1:0] word_inc;
   logic [WORD_W-1:0] word_nxt;
   npc_sel_e          sel;

   assign sel = br_taken ? NPC_BRANCH : NPC_SEQ;

   ifu_pc_reg #(.WORD_W(WORD_W)) u_pc (
      .clk    (clk),
      .rst    (rst),
      .d_word (word_nxt),
      .q_word (word_q)
   );

   ifu_next_pc #(.WORD_W(WORD_W), .IMM_W(IMM_W)) u_npc (
      .cur_word (word_q),
      .sel      (sel),
      .imm      (br_imm),
      .inc_word (word_inc),
      .nxt_word (word_nxt)
   );

   ifu_addr_fmt #(.ADDR_W(ADDR_W), .ALIGN_W(ALIGN_W)) u_fmt (
      .cur_word (word_q),
      .inc_word (word_inc),
      .cur_byte (imem_addr),
      .inc_byte (pc_plus4)
   );

   assign instr = imem_rdata;

   AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
      !br_taken |=> (imem_addr == $past(pc_plus4))); // R3
   AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (rst)
      br_taken |=> (imem_addr[ADDR_W-1:ALIGN_W] ==
         $past(imem_addr[ADDR_W-1:ALIGN_W]) + WORD_W'(1) + WORD_W'(signed'($past(br_imm))))); // R4
   AST_PLUS4_REL: assert property (@(posedge clk) disable iff (rst)
      pc_plus4 == imem_addr + ADDR_W'(STEP_B)); // R7
   AST_RESET_OVER_BRANCH: assert property (@(posedge clk)
      (rst && br_taken) |=> (imem_addr == '0)); // R9
endmodule

// File: tb/ifu_fetch_unit_test.sv
module ifu_fetch_unit_test;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 8;
   // {br_taken, br_imm}
   localparam logic [16:0] VEC [NVEC] = '{
      {1'b0, 16'h0000}, {1'b0, 16'h1234}, {1'b1, 16'h0003}, {1'b0, 16'h0000},
      {1'b1, 16'hFFFE}, {1'b1, 16'h7FFF}, {1'b1, 16'h8000}, {1'b1, 16'h0000}
   };

   logic        clk = 1'b0;
   logic        rst;
   logic        br_taken;
   logic [15:0] br_imm;
   logic [31:0] imem_addr, imem_rdata, instr, pc_plus4;
   int          errors = 0;
   int          checks = 0;
   bit          done = 1'b0;
   logic [29:0] exp_word;

   always #(CLK_PERIOD/2) clk = ~clk;

   // instruction memory model: word derived from its address
   assign imem_rdata = {imem_addr[15:0] ^ 16'hA5A5, imem_addr[31:16]};

   ifu_fetch_unit uut (
      .clk(clk), .rst(rst), .br_taken(br_taken), .br_imm(br_imm),
      .imem_addr(imem_addr), .imem_rdata(imem_rdata),
      .instr(instr), .pc_plus4(pc_plus4)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      logic [31:0] ea;
      ea = {exp_word, 2'b00};
      chk(req, imem_addr, ea);
      chk("R2", {30'd0, imem_addr[1:0]}, 32'd0);
      chk("R7", pc_plus4, ea + 32'd4);
      chk("R8", instr, {ea[15:0] ^ 16'hA5A5, ea[31:16]});
   endtask

   // drive at negedge, let one posedge pass, check at following negedge
   task automatic step(input logic r, input logic bt, input logic [15:0] imm, input string req);
      rst = r; br_taken = bt; br_imm = imm;
      @(negedge clk);
      if (r) exp_word = '0;
      else if (bt) exp_word = exp_word + 30'd1 + {{14{imm[15]}}, imm};
      else exp_word = exp_word + 30'd1;
      check_all(req);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
   end

   initial begin
      rst = 1'b1; br_taken = 1'b0; br_imm = '0; exp_word = '0;
      @(negedge clk);
      step(1'b1, 1'b0, 16'h0, "R1");
      // vector table walk: R3 sequential, R4 branch, R5 negative offsets
      for (int i = 0; i < NVEC; i++) begin
         step(1'b0, VEC[i][16], VEC[i][15:0], VEC[i][16] ? "R4" : "R3");
      end
      // R9: reset wins over a branch in the same edge
      step(1'b1, 1'b1, 16'h0100, "R9");
      // R5: 16'hFFFF from index 4 -> index 4
      step(1'b0, 1'b0, 16'h0, "R3");
      step(1'b0, 1'b0, 16'h0, "R3");
      step(1'b0, 1'b0, 16'h0, "R3");
      step(1'b0, 1'b0, 16'h0, "R3");
      step(1'b0, 1'b1, 16'hFFFF, "R5");
      chk("R5", imem_addr, 32'h0000_0010);
      // R6: reach top word then wrap
      step(1'b1, 1'b0, 16'h0, "R1");
      step(1'b0, 1'b1, 16'hFFFE, "R6");
      chk("R6", imem_addr, 32'hFFFF_FFFC);
      chk("R7", pc_plus4, 32'h0000_0000);
      step(1'b0, 1'b0, 16'h0, "R6");
      chk("R6", imem_addr, 32'h0000_0000);
      finish_run();
   end
endmodule